// File: doc/BRIEF.md
# Math Coprocessor I/O Bus Glue

This block connects a host processor's I/O bus to a math coprocessor. The host sends opcodes and operands to the coprocessor, and reads results back from it, through three I/O port addresses. The glue decodes those addresses into one select line per port, plus read and write command strobes. It also makes a clock enable that pulses once every three system clocks, so the coprocessor logic runs at one third of the host rate from the same clock. The coprocessor's busy line goes to the host's wait input, so a host wait instruction stalls until the coprocessor finishes.

When the coprocessor signals an error, the glue sets a sticky error flag. While the flag is set, the busy indication seen by the host stays asserted and an interrupt request line stays high. Software clears the flag with one specific I/O write: data 00 to port 0F0.

Top module: `copro_bus_glue`

## Requirements
- R1: While `io_rd` or `io_wr` is high, `cop_sel[0]` is high for address 0F8, `cop_sel[1]` for 0FA and `cop_sel[2]` for 0FC. At most one select bit is ever high.
- R2: All select bits are low when both strobes are low, or when the address is not one of the three coprocessor ports.
- R3: `cop_rd` equals `io_rd` and `cop_wr` equals `io_wr` whenever a select bit is high. Both are low otherwise.
- R4: `cop_clk_en` is high in exactly one cycle out of every three. The first pulse comes in the third cycle after reset is released.
- R5: `host_busy` is high whenever `cop_busy` is high or the error flag is set.
- R6: `cop_err` high at a clock edge sets the error flag. From the next cycle on, `err_irq` is high.
- R7: A write to address 0F0 with all eight data bits zero clears the error flag. `err_irq` is low from the next cycle.
- R8: A write to 0F0 with nonzero data, or a read of 0F0, leaves the error flag unchanged.
- R9: If `cop_err` and a clearing write occur in the same cycle, the flag ends up set.
- R10: Synchronous active-high `rst` clears the error flag and the clock-enable counter. Selects and command strobes are low while `rst` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| io_addr | input | 10 | Host I/O address |
| io_rd | input | 1 | Host I/O read strobe |
| io_wr | input | 1 | Host I/O write strobe |
| io_wdata | input | 8 | Host I/O write data (low byte) |
| cop_busy | input | 1 | Coprocessor busy |
| cop_err | input | 1 | Coprocessor error |
| cop_clk_en | output | 1 | One-in-three clock enable for the coprocessor |
| cop_sel | output | 3 | One select per coprocessor port |
| cop_rd | output | 1 | Read command to the coprocessor |
| cop_wr | output | 1 | Write command to the coprocessor |
| host_busy | output | 1 | Busy to the host's wait input |
| err_irq | output | 1 | Interrupt request level 13 |

## Verification
The bench builds the block with its default parameters: a 10-bit address, a divide ratio of three, three ports starting at 0F8 with a stride of two, and clear port 0F0. With these values the three-state counter wraps every few cycles, so the enable phase is checked again and again, including across resets. Random addresses are drawn mostly from the three ports, the clear port, and near-miss neighbours such as 0F9 and 0F1. This puts error and clear collisions, nonzero writes to the clear port, and clear-port reads within easy reach of the random stream, alongside directed cases for each of them.

// File: rtl/copro_bus_glue.sv
module copro_bus_glue #(
  parameter int ADDR_W    = 10,
  parameter int DATA_W    = 8,
  parameter int DIV       = 3,
  parameter int NPORTS    = 3,
  parameter int PORT_BASE = 'h0F8,
  parameter int PORT_STEP = 2,
  parameter int CLR_PORT  = 'h0F0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] io_addr,
  input  logic              io_rd,
  input  logic              io_wr,
  input  logic [DATA_W-1:0] io_wdata,
  input  logic              cop_busy,
  input  logic              cop_err,
  output logic              cop_clk_en,
  output logic [NPORTS-1:0] cop_sel,
  output logic              cop_rd,
  output logic              cop_wr,
  output logic              host_busy,
  output logic              err_irq
);
  localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CNT_W-1:0] div_cnt;
  logic             err_flag;
  logic             strobe, clr_hit, any_sel;

  assign strobe = !rst && (io_rd || io_wr);

  for (genvar i = 0; i < NPORTS; i++) begin : g_sel
    assign cop_sel[i] = strobe && (io_addr == ADDR_W'(PORT_BASE + i * PORT_STEP));
  end

  assign any_sel = |cop_sel;
  assign cop_rd  = any_sel && io_rd;
  assign cop_wr  = any_sel && io_wr;

  always_ff @(posedge clk) begin
    if (rst || div_cnt == CNT_W'(DIV - 1)) div_cnt <= '0;
    else                                   div_cnt <= div_cnt + 1'b1;
  end
  assign cop_clk_en = (div_cnt == CNT_W'(DIV - 1));

  assign clr_hit = io_wr && (io_addr == ADDR_W'(CLR_PORT)) && (io_wdata == '0);

  always_ff @(posedge clk) begin
    if (rst)          err_flag <= 1'b0;
    else if (cop_err) err_flag <= 1'b1;
    else if (clr_hit) err_flag <= 1'b0;
  end

  assign err_irq   = err_flag;
  assign host_busy = cop_busy || err_flag;

  a_r1_sel_onehot: assert property (@(posedge clk) disable iff (rst) $onehot0(cop_sel));
  a_r2_idle_no_sel: assert property (@(posedge clk) disable iff (rst)
    !(io_rd || io_wr) |-> (cop_sel == '0 && !cop_rd && !cop_wr));
  a_r4_en_single: assert property (@(posedge clk) disable iff (rst) cop_clk_en |=> !cop_clk_en);
  a_r5_busy_hold: assert property (@(posedge clk) disable iff (rst) err_irq |-> host_busy);
  a_r6_err_sets: assert property (@(posedge clk) disable iff (rst) cop_err |=> err_irq);
  a_r8_keep: assert property (@(posedge clk) disable iff (rst)
    (err_irq && !(io_wr && io_addr == ADDR_W'(CLR_PORT) && io_wdata == '0)) |=> err_irq);
  a_r7_clear: assert property (@(posedge clk) disable iff (rst)
    (io_wr && io_addr == ADDR_W'(CLR_PORT) && io_wdata == '0 && !cop_err) |=> !err_irq);
endmodule

// File: tb/tb_copro_bus_glue.sv
module tb_copro_bus_glue;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst = 1'b1;
  logic [9:0] io_addr = '0;
  logic       io_rd = 1'b0, io_wr = 1'b0;
  logic [7:0] io_wdata = '0;
  logic       cop_busy = 1'b0, cop_err = 1'b0;
  logic       cop_clk_en, cop_rd, cop_wr, host_busy, err_irq;
  logic [2:0] cop_sel;

  int checks = 0, errors = 0;
  bit m_lat = 1'b0;
  int m_cnt = 0;

  copro_bus_glue dut (
    .clk(clk), .rst(rst), .io_addr(io_addr), .io_rd(io_rd), .io_wr(io_wr),
    .io_wdata(io_wdata), .cop_busy(cop_busy), .cop_err(cop_err),
    .cop_clk_en(cop_clk_en), .cop_sel(cop_sel), .cop_rd(cop_rd), .cop_wr(cop_wr),
    .host_busy(host_busy), .err_irq(err_irq));

  always #(CLK_PERIOD / 2) clk = ~clk;

  function automatic logic [2:0] exp_sel(input logic [9:0] a, input logic rd, wr, r);
    exp_sel = '0;
    if (!r && (rd || wr)) begin
      if (a == 10'h0F8) exp_sel = 3'b001;
      if (a == 10'h0FA) exp_sel = 3'b010;
      if (a == 10'h0FC) exp_sel = 3'b100;
    end
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input logic [9:0] a, input logic rd, wr, input logic [7:0] d,
                      input logic b, e, r);
    logic [2:0] es;
    @(negedge clk);
    io_addr = a; io_rd = rd; io_wr = wr; io_wdata = d; cop_busy = b; cop_err = e; rst = r;
    #1;
    es = exp_sel(a, rd, wr, r);
    if (r)                 chk(cop_sel == es, "R10", cop_sel, es);
    else if (es != 0)      chk(cop_sel == es, "R1", cop_sel, es);
    else                   chk(cop_sel == es, "R2", cop_sel, es);
    chk(cop_rd == (es != 0 && rd), "R3", cop_rd, es != 0 && rd);
    chk(cop_wr == (es != 0 && wr), "R3", cop_wr, es != 0 && wr);
    chk(cop_clk_en == (m_cnt == 2), "R4", cop_clk_en, m_cnt == 2);
    chk(host_busy == (b || m_lat), "R5", host_busy, b || m_lat);
    chk(err_irq == m_lat, (a == 10'h0F0) ? "R8" : "R6", err_irq, m_lat);
    if (r) begin m_lat = 0; m_cnt = 0; end
    else begin
      m_cnt = (m_cnt == 2) ? 0 : m_cnt + 1;
      if (e) m_lat = 1;
      else if (wr && a == 10'h0F0 && d == 0) m_lat = 0;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [9:0] pool [8];
    void'($urandom(32'h5EED));
    pool = '{10'h0F8, 10'h0FA, 10'h0FC, 10'h0F0, 10'h0F9, 10'h0F1, 10'h0FE, 10'h2F8};
    step(10'h0F8, 1, 0, 0, 0, 0, 1);          // R10 selects low in reset
    step(10'h0F8, 0, 1, 0, 0, 0, 1);
    @(negedge clk); #1;
    chk(err_irq == 0, "R10", err_irq, 0);
    // R4 phase after release
    step(10'h000, 0, 0, 0, 0, 0, 0);
    step(10'h000, 0, 0, 0, 0, 0, 0);
    step(10'h000, 0, 0, 0, 0, 0, 0);
    // R6 set, R8 nonzero write and read ignored, R7 clear
    step(10'h0FA, 0, 1, 8'h12, 0, 1, 0);
    step(10'h0F0, 0, 1, 8'h01, 0, 0, 0);
    step(10'h0F0, 1, 0, 8'h00, 0, 0, 0);
    step(10'h0F0, 0, 1, 8'h80, 1, 0, 0);
    step(10'h0F0, 0, 1, 8'h00, 0, 0, 0);
    step(10'h0FC, 1, 0, 8'h00, 0, 0, 0);
    chk(err_irq == 0, "R7", err_irq, 0);
    // R9 collision: error wins
    step(10'h0F0, 0, 1, 8'h00, 0, 1, 0);
    step(10'h0F0, 0, 1, 8'h00, 0, 1, 0);
    step(10'h000, 0, 0, 8'h00, 0, 0, 0);
    chk(err_irq == 1, "R9", err_irq, 1);
    step(10'h0F0, 0, 1, 8'h00, 0, 0, 0);
    step(10'h000, 0, 0, 8'h00, 0, 0, 0);
    // R10 reset clears a set flag
    step(10'h000, 0, 0, 8'h00, 0, 1, 0);
    step(10'h000, 0, 0, 8'h00, 0, 0, 1);
    step(10'h000, 0, 0, 8'h00, 0, 0, 0);
    for (int i = 0; i < 3000; i++) begin
      int k = $urandom_range(0, 7);
      int m = $urandom_range(0, 3);
      step(pool[k], m == 1 || m == 3 && 0, m == 2 || m == 3,
           ($urandom_range(0, 1) != 0) ? 8'h00 : 8'($urandom_range(1, 255)),
           $urandom_range(0, 3) == 0, $urandom_range(0, 15) == 0,
           $urandom_range(0, 199) == 0);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule